// File: doc/BRIEF.md
# Security Interrupt Status Aggregator

This block gathers the level-sensitive interrupt status lines of a security subsystem's protection checkers into a small bank of 32-bit registers. The status lines come from three groups of checkers: the peripheral-protection checkers, the memory-protection checkers and the expansion master-security checkers. The block holds the enable registers for two of those groups. It does not act on enable or clear locally. Instead it fans them out as one enable line and one clear line per checker, and the checkers act on them. It also drives one combined master-security interrupt.

Software reaches the block through a word-oriented register port: byte address, write data, write enable and an access size (0 = byte, 1 = halfword, 2 = word). Read data is combinational on the address. The word map at byte offsets is:

- 0x00: peripheral status (RO)
- 0x04: peripheral clear (WO)
- 0x08: peripheral enable
- 0x0C: memory-checker status (RO)
- 0x10: master-security status (RO)
- 0x14: master-security clear (WO)
- 0x18: master-security enable
- 0x1C: bridge status (RO)
- 0x20: bridge clear (WO)
- 0x24: bridge enable

Unmapped and write-only words read as zero.

Top module: `sec_irq_agg`

## Requirements
- R1: Reset (synchronous, active low) clears the peripheral status, peripheral enable, master-security enable and bridge enable registers. All enable and clear outputs read 0 after reset.
- R2: The peripheral status register (0x00) is sampled from the inputs one cycle late. The internal APB checker i sits at bit i, APB expansion checker i at bit 4+i, and AHB expansion checker i at bit 20+i. All other bits read 0.
- R3: A word write to the peripheral enable register (0x08) stores the data ANDed with 0x00F000F3. Each checker's enable output equals its bit (same positions as R2) of the stored value, from the cycle after the write.
- R4: A word write to the peripheral clear register (0x04) drives, for exactly the cycle after the write, each checker's clear output with that checker's bit of the current peripheral status. At all other times the clear outputs are 0.
- R5: The memory-checker status register (0x0C) shows internal memory checker n at bit n and expansion memory checker n at bit n+16, live from the inputs.
- R6: The master-security status register (0x10) shows expansion input n at bit n+16, live. The combined interrupt equals the OR of (status AND stored enable, 0x18), and it responds in the same cycle as an input change.
- R7: A word write to the master-security clear register (0x14) drives clear output n with bit n+16 of the written data for exactly the next cycle; otherwise those outputs are 0.
- R8: The bridge status register (0x1C) always reads 0. A write to its clear register (0x20) changes nothing. The bridge enable register (0x24) keeps only bits 31..16 of a written value.
- R9: Writes whose size is not 2 (word), or whose address is not word aligned, change no register and produce no clear pulse.
- R10: Writes to the read-only status registers (0x00, 0x0C, 0x10, 0x1C) change no stored state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable |
| reg_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| reg_rdata | output | 32 | Combinational read data |
| pchk_apb_st | input | NUM_APB | Status of internal APB peripheral checkers |
| pchk_apbx_st | input | NUM_APBX | Status of APB expansion peripheral checkers |
| pchk_ahbx_st | input | NUM_AHBX | Status of AHB expansion peripheral checkers |
| pchk_apb_en | output | NUM_APB | Enable fan-out, internal APB checkers |
| pchk_apbx_en | output | NUM_APBX | Enable fan-out, APB expansion checkers |
| pchk_ahbx_en | output | NUM_AHBX | Enable fan-out, AHB expansion checkers |
| pchk_apb_clr | output | NUM_APB | Clear pulse, internal APB checkers |
| pchk_apbx_clr | output | NUM_APBX | Clear pulse, APB expansion checkers |
| pchk_ahbx_clr | output | NUM_AHBX | Clear pulse, AHB expansion checkers |
| mchk_int_st | input | NUM_MPC | Status of internal memory checkers |
| mchk_exp_st | input | NUM_MPCX | Status of expansion memory checkers |
| msec_st | input | NUM_MSC | Status of expansion master-security checkers |
| msec_clr | output | NUM_MSC | Clear pulse, master-security checkers |
| msec_irq | output | 1 | Combined master-security interrupt |

## Verification
The bench goes after the scattered bit placement by sweeping every peripheral status pattern. A design with a wrong group offset would show set bits in the gap between bits 8 and 19, or in bits 2..3. The enable mask is probed one bit at a time, which catches a mask that lets a reserved bit through or drops a checker's bit. The clear pulse is checked for both its value and its one-cycle width, catching a pulse that sticks or clears from the wrong register. The combined interrupt is swept over all status and enable pairs in the same cycle as the input change, so a registered or wrongly masked interrupt shows up at once. Sub-word, misaligned and read-only writes are each followed by read-back of the register they might have hit.

// File: rtl/sec_irq_pkg.sv
// Shared constants and types for the security interrupt status aggregator.
// Assumes a 32-bit data path and a word map that fits in ADDR_W byte bits.
package sec_irq_pkg;

    // Word indices of the register map (byte offset = index * 4)
    localparam int WI_PSTAT = 0;
    localparam int WI_PCLR  = 1;
    localparam int WI_PEN   = 2;
    localparam int WI_MSTAT = 3;
    localparam int WI_SSTAT = 4;
    localparam int WI_SCLR  = 5;
    localparam int WI_SEN   = 6;
    localparam int WI_BSTAT = 7;
    localparam int WI_BCLR  = 8;
    localparam int WI_BEN   = 9;

    // Fixed bit positions decoded by software
    localparam int APB_BIT  = 0;
    localparam int APBX_BIT = 4;
    localparam int AHBX_BIT = 20;
    localparam int HI_BIT   = 16;

    localparam logic [31:0] BRG_EN_MASK = 32'hFFFF_0000;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic pen;
        logic pclr;
        logic sen;
        logic sclr;
        logic ben;
    } wr_strobe_t;

endpackage

// File: rtl/sec_irq_regif.sv
// Register decoder: turns an access into per-register write strobes and
// multiplexes stored/live values onto the read bus.
// Assumes only aligned word writes are legal; reads ignore the low bits.
module sec_irq_regif
    import sec_irq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [31:0]       pstat,
    input  logic [31:0]       pen,
    input  logic [31:0]       mstat,
    input  logic [31:0]       sstat,
    input  logic [31:0]       sen,
    input  logic [31:0]       ben,
    output wr_strobe_t        strobe,
    output logic [31:0]       rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word;
    logic             wr_ok;

    // Qualify the write: word size and word aligned only
    always_comb begin
        word  = addr[ADDR_W-1:2];
        wr_ok = we && (size == SZ_WORD) && (addr[1:0] == 2'b00);
    end

    // Decode the write strobes; status words never get one
    always_comb begin
        strobe      = '0;
        strobe.pen  = wr_ok && (word == IDX_W'(WI_PEN));
        strobe.pclr = wr_ok && (word == IDX_W'(WI_PCLR));
        strobe.sen  = wr_ok && (word == IDX_W'(WI_SEN));
        strobe.sclr = wr_ok && (word == IDX_W'(WI_SCLR));
        strobe.ben  = wr_ok && (word == IDX_W'(WI_BEN));
    end

    // Read multiplexer; clear words, bridge status and holes read zero
    always_comb begin
        rdata = '0;
        if (word == IDX_W'(WI_PSTAT)) rdata = pstat;
        if (word == IDX_W'(WI_PEN))   rdata = pen;
        if (word == IDX_W'(WI_MSTAT)) rdata = mstat;
        if (word == IDX_W'(WI_SSTAT)) rdata = sstat;
        if (word == IDX_W'(WI_SEN))   rdata = sen;
        if (word == IDX_W'(WI_BEN))   rdata = ben;
    end

endmodule

// File: rtl/sec_irq_pchk_bank.sv
// Peripheral-checker bank: samples the three checker groups into a status
// word at fixed bit positions, holds the enable word and produces per-checker
// enable levels and one-cycle clear pulses.
// Assumes group counts fit their fields (APB <= 4, expansion <= 16 / 12).
module sec_irq_pchk_bank
    import sec_irq_pkg::*;
#(
    parameter int NUM_APB  = 2,
    parameter int NUM_APBX = 4,
    parameter int NUM_AHBX = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_clr,
    input  logic [31:0]         wdata,
    input  logic [NUM_APB-1:0]  apb_st,
    input  logic [NUM_APBX-1:0] apbx_st,
    input  logic [NUM_AHBX-1:0] ahbx_st,
    output logic [31:0]         stat_q,
    output logic [31:0]         en_q,
    output logic [NUM_APB-1:0]  apb_en,
    output logic [NUM_APBX-1:0] apbx_en,
    output logic [NUM_AHBX-1:0] ahbx_en,
    output logic [NUM_APB-1:0]  apb_clr,
    output logic [NUM_APBX-1:0] apbx_clr,
    output logic [NUM_AHBX-1:0] ahbx_clr
);
    localparam logic [31:0] APB_M  = ((32'h1 << NUM_APB)  - 32'h1) << APB_BIT;
    localparam logic [31:0] APBX_M = ((32'h1 << NUM_APBX) - 32'h1) << APBX_BIT;
    localparam logic [31:0] AHBX_M = ((32'h1 << NUM_AHBX) - 32'h1) << AHBX_BIT;
    localparam logic [31:0] EN_MASK = APB_M | APBX_M | AHBX_M;

    logic [31:0]         stat_d;
    logic [NUM_APB-1:0]  apb_clr_q;
    logic [NUM_APBX-1:0] apbx_clr_q;
    logic [NUM_AHBX-1:0] ahbx_clr_q;

    // Scatter the group inputs onto their fixed status bits
    always_comb begin
        stat_d = '0;
        stat_d[APB_BIT  +: NUM_APB]  = apb_st;
        stat_d[APBX_BIT +: NUM_APBX] = apbx_st;
        stat_d[AHBX_BIT +: NUM_AHBX] = ahbx_st;
    end

    // Status sample register
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Enable register, masked to implemented checker bits
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata & EN_MASK;
    end

    // One-cycle clear pulses taken from the current status
    always_ff @(posedge clk) begin
        if (!rst_n || !wr_clr) begin
            apb_clr_q  <= '0;
            apbx_clr_q <= '0;
            ahbx_clr_q <= '0;
        end else begin
            apb_clr_q  <= stat_q[APB_BIT  +: NUM_APB];
            apbx_clr_q <= stat_q[APBX_BIT +: NUM_APBX];
            ahbx_clr_q <= stat_q[AHBX_BIT +: NUM_AHBX];
        end
    end

    // Per-checker fan-out of enable levels and clear pulses
    for (genvar i = 0; i < NUM_APB; i++) begin : g_apb
        assign apb_en[i]  = en_q[APB_BIT + i];
        assign apb_clr[i] = apb_clr_q[i];
    end
    for (genvar i = 0; i < NUM_APBX; i++) begin : g_apbx
        assign apbx_en[i]  = en_q[APBX_BIT + i];
        assign apbx_clr[i] = apbx_clr_q[i];
    end
    for (genvar i = 0; i < NUM_AHBX; i++) begin : g_ahbx
        assign ahbx_en[i]  = en_q[AHBX_BIT + i];
        assign ahbx_clr[i] = ahbx_clr_q[i];
    end

endmodule

// File: rtl/sec_irq_msec_bank.sv
// Master-security bank: live status in the upper half-word, full-width enable
// register, combinational combined interrupt and one-cycle clear pulses.
// Assumes NUM_MSC <= 16.
module sec_irq_msec_bank
    import sec_irq_pkg::*;
#(
    parameter int NUM_MSC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_clr,
    input  logic [31:0]        wdata,
    input  logic [NUM_MSC-1:0] st_in,
    output logic [31:0]        stat,
    output logic [31:0]        en_q,
    output logic [NUM_MSC-1:0] clr,
    output logic               irq
);
    // Place live status inputs at bit n+16
    always_comb begin
        stat = '0;
        stat[HI_BIT +: NUM_MSC] = st_in;
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata;
    end

    // Clear pulses from the upper half of the written data
    always_ff @(posedge clk) begin
        if (!rst_n || !wr_clr) clr <= '0;
        else                   clr <= wdata[HI_BIT +: NUM_MSC];
    end

    // Combined interrupt, no register stage
    always_comb irq = |(stat & en_q);

endmodule

// File: rtl/sec_irq_agg.sv
// Top of the security interrupt status aggregator. Wires the register
// decoder, the peripheral and master-security banks, the memory-checker
// status view and the bridge enable register.
// Assumes NUM_MPC and NUM_MPCX <= 16.
module sec_irq_agg
    import sec_irq_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_APB  = 2,
    parameter int NUM_APBX = 4,
    parameter int NUM_AHBX = 4,
    parameter int NUM_MPC  = 4,
    parameter int NUM_MPCX = 4,
    parameter int NUM_MSC  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    input  logic                reg_we,
    input  logic [1:0]          reg_size,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_APB-1:0]  pchk_apb_st,
    input  logic [NUM_APBX-1:0] pchk_apbx_st,
    input  logic [NUM_AHBX-1:0] pchk_ahbx_st,
    output logic [NUM_APB-1:0]  pchk_apb_en,
    output logic [NUM_APBX-1:0] pchk_apbx_en,
    output logic [NUM_AHBX-1:0] pchk_ahbx_en,
    output logic [NUM_APB-1:0]  pchk_apb_clr,
    output logic [NUM_APBX-1:0] pchk_apbx_clr,
    output logic [NUM_AHBX-1:0] pchk_ahbx_clr,
    input  logic [NUM_MPC-1:0]  mchk_int_st,
    input  logic [NUM_MPCX-1:0] mchk_exp_st,
    input  logic [NUM_MSC-1:0]  msec_st,
    output logic [NUM_MSC-1:0]  msec_clr,
    output logic                msec_irq
);
    wr_strobe_t  strobe;
    logic [31:0] pstat, pen, mstat, sstat, sen, ben_q;

    sec_irq_regif #(.ADDR_W(ADDR_W)) u_regif (
        .addr   (reg_addr),
        .we     (reg_we),
        .size   (reg_size),
        .pstat  (pstat),
        .pen    (pen),
        .mstat  (mstat),
        .sstat  (sstat),
        .sen    (sen),
        .ben    (ben_q),
        .strobe (strobe),
        .rdata  (reg_rdata)
    );

    sec_irq_pchk_bank #(
        .NUM_APB(NUM_APB), .NUM_APBX(NUM_APBX), .NUM_AHBX(NUM_AHBX)
    ) u_pchk (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (strobe.pen),
        .wr_clr   (strobe.pclr),
        .wdata    (reg_wdata),
        .apb_st   (pchk_apb_st),
        .apbx_st  (pchk_apbx_st),
        .ahbx_st  (pchk_ahbx_st),
        .stat_q   (pstat),
        .en_q     (pen),
        .apb_en   (pchk_apb_en),
        .apbx_en  (pchk_apbx_en),
        .ahbx_en  (pchk_ahbx_en),
        .apb_clr  (pchk_apb_clr),
        .apbx_clr (pchk_apbx_clr),
        .ahbx_clr (pchk_ahbx_clr)
    );

    sec_irq_msec_bank #(.NUM_MSC(NUM_MSC)) u_msec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (strobe.sen),
        .wr_clr (strobe.sclr),
        .wdata  (reg_wdata),
        .st_in  (msec_st),
        .stat   (sstat),
        .en_q   (sen),
        .clr    (msec_clr),
        .irq    (msec_irq)
    );

    // Memory-checker status view: internal at bit n, expansion at n+16
    always_comb begin
        mstat = '0;
        mstat[0      +: NUM_MPC]  = mchk_int_st;
        mstat[HI_BIT +: NUM_MPCX] = mchk_exp_st;
    end

    // Bridge enable register, upper half only; strobe.ben covers 0x24
    always_ff @(posedge clk) begin
        if (!rst_n)          ben_q <= '0;
        else if (strobe.ben) ben_q <= reg_wdata & BRG_EN_MASK;
    end

endmodule

// File: rtl/sec_irq_agg_chk.sv
// Assertion checker for sec_irq_agg, attached by bind below.
module sec_irq_agg_chk
    import sec_irq_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_APB  = 2,
    parameter int NUM_APBX = 4,
    parameter int NUM_AHBX = 4,
    parameter int NUM_MSC  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_wdata,
    input logic                reg_we,
    input logic [1:0]          reg_size,
    input logic [31:0]         reg_rdata,
    input logic [NUM_APB-1:0]  pchk_apb_en,
    input logic [NUM_APBX-1:0] pchk_apbx_en,
    input logic [NUM_AHBX-1:0] pchk_ahbx_en,
    input logic [NUM_APB-1:0]  pchk_apb_clr,
    input logic [NUM_APBX-1:0] pchk_apbx_clr,
    input logic [NUM_AHBX-1:0] pchk_ahbx_clr,
    input logic [NUM_MSC-1:0]  msec_st,
    input logic [NUM_MSC-1:0]  msec_clr,
    input logic                msec_irq
);
    logic wword;
    logic wr_pen, wr_pclr, wr_sclr, sub_pen;
    always_comb begin
        wword   = reg_we && (reg_size == SZ_WORD) && (reg_addr[1:0] == 2'b00);
        wr_pen  = wword && (reg_addr == ADDR_W'(WI_PEN * 4));
        wr_pclr = wword && (reg_addr == ADDR_W'(WI_PCLR * 4));
        wr_sclr = wword && (reg_addr == ADDR_W'(WI_SCLR * 4));
        sub_pen = reg_we && (reg_size != SZ_WORD) && (reg_addr == ADDR_W'(WI_PEN * 4));
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (pchk_apb_en == '0 && pchk_apbx_en == '0 && pchk_ahbx_en == '0
                    && msec_clr == '0 && !msec_irq));

    p_en_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pen |=> (pchk_apb_en  == $past(reg_wdata[APB_BIT  +: NUM_APB])
                 && pchk_apbx_en == $past(reg_wdata[APBX_BIT +: NUM_APBX])
                 && pchk_ahbx_en == $past(reg_wdata[AHBX_BIT +: NUM_AHBX])));

    p_clr_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pclr |=> (pchk_apb_clr == '0 && pchk_apbx_clr == '0 && pchk_ahbx_clr == '0));

    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msec_st == '0) |-> !msec_irq);

    p_msec_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sclr |=> (msec_clr == $past(reg_wdata[HI_BIT +: NUM_MSC])));

    p_msec_clr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sclr |=> (msec_clr == '0));

    p_brg_stat_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(WI_BSTAT * 4)) |-> (reg_rdata == '0));

    p_subword_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sub_pen |=> ($stable(pchk_apb_en) && $stable(pchk_apbx_en) && $stable(pchk_ahbx_en)));

endmodule

bind sec_irq_agg sec_irq_agg_chk #(
    .ADDR_W(ADDR_W), .NUM_APB(NUM_APB), .NUM_APBX(NUM_APBX),
    .NUM_AHBX(NUM_AHBX), .NUM_MSC(NUM_MSC)
) u_sec_irq_agg_chk (.*);

// File: tb/sec_irq_agg_tb_top.sv
// Self-checking bench for sec_irq_agg in its default configuration.
module sec_irq_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_size = 2'd2;
    logic [31:0] reg_rdata;
    logic [1:0]  apb_st = '0;
    logic [3:0]  apbx_st = '0, ahbx_st = '0;
    logic [1:0]  apb_en, apb_clr;
    logic [3:0]  apbx_en, ahbx_en, apbx_clr, ahbx_clr;
    logic [3:0]  mpc_st = '0, mpcx_st = '0, msc_st = '0, msc_clr;
    logic        msc_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sec_irq_agg dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_size(reg_size), .reg_rdata(reg_rdata),
        .pchk_apb_st(apb_st), .pchk_apbx_st(apbx_st), .pchk_ahbx_st(ahbx_st),
        .pchk_apb_en(apb_en), .pchk_apbx_en(apbx_en), .pchk_ahbx_en(ahbx_en),
        .pchk_apb_clr(apb_clr), .pchk_apbx_clr(apbx_clr), .pchk_ahbx_clr(ahbx_clr),
        .mchk_int_st(mpc_st), .mchk_exp_st(mpcx_st), .msec_st(msc_st),
        .msec_clr(msc_clr), .msec_irq(msc_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_size = sz; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_size = 2'd2;
        #1;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] pmap(input logic [1:0] a, input logic [3:0] x, input logic [3:0] h);
        return 32'(a) | (32'(x) << 4) | (32'(h) << 20);
    endfunction

    function automatic logic [31:0] pen_flat();
        return pmap(apb_en, apbx_en, ahbx_en);
    endfunction

    function automatic logic [31:0] pclr_flat();
        return pmap(apb_clr, apbx_clr, ahbx_clr);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(6'(a * 4), r);
            chk("R1 reset read", r, 32'h0);
        end
        chk("R1 reset enables", pen_flat(), 32'h0);
        chk("R1 reset clears", pclr_flat() | 32'(msc_clr) | 32'(msc_irq), 32'h0);

        // R2: exhaustive peripheral status placement
        for (int p = 0; p < 1024; p++) begin
            @(negedge clk);
            apb_st = p[1:0]; apbx_st = p[5:2]; ahbx_st = p[9:6];
            @(negedge clk);
            #1;
            rd(6'h00, r);
            chk("R2 status map", r, pmap(p[1:0], p[5:2], p[9:6]));
        end

        // R3: walking enable bits and full write
        for (int b = 0; b < 32; b++) begin
            wr(6'h08, 32'h1 << b, 2'd2);
            rd(6'h08, r);
            chk("R3 enable store", r, (32'h1 << b) & 32'h00F000F3);
            chk("R3 enable fanout", pen_flat(), (32'h1 << b) & 32'h00F000F3);
        end
        wr(6'h08, 32'hFFFF_FFFF, 2'd2);
        rd(6'h08, r);
        chk("R3 enable all", r, 32'h00F000F3);

        // R4: clear pulse carries status for exactly one cycle
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            apb_st = p[1:0]; apbx_st = {p[3:0]}; ahbx_st = ~p[3:0];
            @(negedge clk);
            wr(6'h04, 32'h0, 2'd2);
            chk("R4 clear pulse", pclr_flat(), pmap(p[1:0], p[3:0], ~p[3:0]));
            @(negedge clk);
            #1;
            chk("R4 clear ends", pclr_flat(), 32'h0);
        end

        // R5: memory-checker status placement
        for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            mpc_st = p[3:0]; mpcx_st = p[7:4];
            #1;
            rd(6'h0C, r);
            chk("R5 mem status", r, 32'(p[3:0]) | (32'(p[7:4]) << 16));
        end

        // R6: combined interrupt, same cycle as input change
        for (int e = 0; e < 16; e++) begin
            wr(6'h18, (32'(e) << 16) | 32'h0000_FFFF, 2'd2);
            for (int s = 0; s < 16; s++) begin
                msc_st = s[3:0];
                #1;
                chk("R6 irq", 32'(msc_irq), 32'(|(s[3:0] & e[3:0])));
                rd(6'h10, r);
                chk("R6 status", r, 32'(s) << 16);
            end
        end

        // R7: master-security clear pulse
        for (int v = 0; v < 16; v++) begin
            wr(6'h14, (32'(v) << 16) | 32'h0000_000F, 2'd2);
            chk("R7 clear pulse", 32'(msc_clr), 32'(v));
            @(negedge clk);
            #1;
            chk("R7 clear ends", 32'(msc_clr), 32'h0);
        end

        // R8: bridge registers
        wr(6'h24, 32'hDEAD_BEEF, 2'd2);
        rd(6'h24, r);
        chk("R8 bridge enable mask", r, 32'hDEAD_0000);
        wr(6'h20, 32'hFFFF_FFFF, 2'd2);
        rd(6'h24, r);
        chk("R8 bridge clear no effect", r, 32'hDEAD_0000);
        rd(6'h1C, r);
        chk("R8 bridge status zero", r, 32'h0);

        // R9: sub-word and misaligned writes ignored
        wr(6'h08, 32'h0000_0001, 2'd2);
        wr(6'h08, 32'hFFFF_FFFF, 2'd0);
        wr(6'h08, 32'hFFFF_FFFF, 2'd1);
        wr(6'h09, 32'hFFFF_FFFF, 2'd2);
        rd(6'h08, r);
        chk("R9 subword enable", r, 32'h0000_0001);
        chk("R9 subword fanout", pen_flat(), 32'h0000_0001);
        wr(6'h14, 32'hFFFF_FFFF, 2'd0);
        chk("R9 subword msec clear", 32'(msc_clr), 32'h0);
        wr(6'h04, 32'h0, 2'd1);
        chk("R9 subword pclear", pclr_flat(), 32'h0);
        wr(6'h24, 32'h1234_0000, 2'd1);
        rd(6'h24, r);
        chk("R9 subword bridge", r, 32'hDEAD_0000);

        // R10: read-only writes ignored, holes read zero
        @(negedge clk);
        apb_st = 2'b01; apbx_st = 4'h2; ahbx_st = 4'h8; msc_st = 4'h0;
        wr(6'h18, 32'h0, 2'd2);
        wr(6'h00, 32'hFFFF_FFFF, 2'd2);
        wr(6'h0C, 32'hFFFF_FFFF, 2'd2);
        wr(6'h10, 32'hFFFF_FFFF, 2'd2);
        wr(6'h1C, 32'hFFFF_FFFF, 2'd2);
        rd(6'h00, r);
        chk("R10 pstat unchanged", r, pmap(2'b01, 4'h2, 4'h8));
        rd(6'h08, r);
        chk("R10 penable unchanged", r, 32'h0000_0001);
        rd(6'h18, r);
        chk("R10 senable unchanged", r, 32'h0);
        rd(6'h24, r);
        chk("R10 bridge unchanged", r, 32'hDEAD_0000);
        for (int a = 10; a < 16; a++) begin
            rd(6'(a * 4), r);
            chk("R10 hole reads zero", r, 32'h0);
        end

        // R1: reset again clears stored state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apb_st = '0; apbx_st = '0; ahbx_st = '0;
        #1;
        rd(6'h08, r);
        chk("R1 reset enable", r, 32'h0);
        rd(6'h24, r);
        chk("R1 reset bridge", r, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule